// File: doc/BRIEF.md
# Parallel I/O Ports with Software Float Mode

This block gives a chip three parallel ports, A, B and C, each `PORT_W` bits wide. Port C is split into an upper and a lower half. Each of the four groups (A, B, C upper, C lower) is set as an input or an output by a control byte. Software reaches the output latches, the pad readback and the direction settings through a small byte-addressed write/read interface. Every pad is modelled as an output value plus an output enable. Pull-ups outside the block make a pad that nobody drives read as logic one.

A static mode pin selects between two behaviours for control-byte writes. In normal operation, a control-byte write clears every latch and drives the new output groups at once. In float mode, the same write also takes every pad out of drive. Software can then reload the latches while the pads stay quiet. Writing a dedicated release bit then makes all output groups start driving on the same clock edge.

Top module: `pio_tristate_ports`

Register offsets on `bus_addr`:
- 0: port A
- 1: port B
- 2: port C
- 3: control
- 4: release

## Requirements
- R1: After reset, all four groups are inputs, every latch is zero, every `pin_oe` bit is low and the float flag is clear.
- R2: A write to offset 3 with bit 7 set is a mode word. It sets the direction of each group: bit 0 for port A, bit 1 for port B, bit 2 for C upper, bit 3 for C lower, where 1 means input. In the cycle after the write, `pin_oe` is high exactly on the bits of output groups, unless the block is floated.
- R3: A mode word clears all output latches (`pin_out`) to zero in the cycle after the write.
- R4: A write to offset 0, 1 or 2 loads the latch of each addressed group that is an output. For offset 2, data bits [PORT_W-1:PORT_W/2] go to C upper and the lower bits go to C lower. A group that is an input keeps its latch, and no other port is affected.
- R5: Reads at offsets 0, 1 and 2 return the present pad values of that port. Offset 3 returns bit 7 set with the four direction bits in bits [3:0]. Offset 4 returns the float flag in bit 0. Reads are combinational.
- R6: A write to offset 3 with bit 7 clear is a single-bit command on port C. Bits [3:1] give the bit index, where indices 0 to PORT_W/2-1 fall in the lower half. Bit 0 gives the new value. The command acts only if the target half is an output. It never changes the directions, the other latch bits or the float flag.
- R7: With `tri_mode` high, a mode word sets the float flag. In the next cycle every `pin_oe` bit is low, while the latch clearing and the direction update still take effect.
- R8: While floated, port writes update `pin_out` of output groups but leave every `pin_oe` bit low.
- R9: A write to offset 4 with bit 0 set clears the float flag, so all output groups drive together in the next cycle. A write to offset 4 with bit 0 clear has no effect.
- R10: With `tri_mode` low, the float flag never sets, and release writes change nothing at the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_mode | input | 1 | Static select: 1 = float mode, 0 = normal |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register offset for writes and reads |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data for `bus_addr` |
| pad_in | input | 3*PORT_W | Sensed pad levels, {C, B, A} |
| pin_out | output | 3*PORT_W | Output latch values, {C, B, A} |
| pin_oe | output | 3*PORT_W | Per-pad output enable, {C, B, A} |

## Verification
The bench uses the default `PORT_W` of 8, so the 3-bit index field of the single-bit command covers both halves of port C. The bench runs the whole sequence twice, once with `tri_mode` low and once with it high, changing the pin only under reset. Random writes over all five offsets mix mode words, single-bit commands, releases and port writes in every direction pattern. Random external pad levels make the readback of input and floated pins distinct from the latch values.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_A    = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_B    = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_C    = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_REL  = 3'd4;

  localparam int unsigned NGRP = 4;
  localparam int unsigned GRP_A  = 0;
  localparam int unsigned GRP_B  = 1;
  localparam int unsigned GRP_CH = 2;
  localparam int unsigned GRP_CL = 3;

  function automatic logic is_mode_word(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic [NGRP-1:0] dir_field(input logic [7:0] b);
    return b[NGRP-1:0];
  endfunction
endpackage

// File: rtl/pio_bus_dec.sv
module pio_bus_dec
  import pio_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned IDX_W = $clog2(PORT_W)
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [2:0]        port_wr,
  output logic              mode_wr,
  output logic              bsr_wr,
  output logic              rel_wr,
  output logic [NGRP-1:0]   new_dir,
  output logic [IDX_W-1:0]  bsr_idx,
  output logic              bsr_val
);
  logic ctrl_hit;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ctrl_hit = bus_we && (bus_addr == OFS_CTRL);

  assign port_wr[0] = bus_we && (bus_addr == OFS_A);
  assign port_wr[1] = bus_we && (bus_addr == OFS_B);
  assign port_wr[2] = bus_we && (bus_addr == OFS_C);

  assign mode_wr = ctrl_hit && is_mode_word(bus_wdata[7:0]);
  assign bsr_wr  = ctrl_hit && !is_mode_word(bus_wdata[7:0]);
  assign rel_wr  = bus_we && (bus_addr == OFS_REL) && bus_wdata[0];

  assign new_dir = dir_field(bus_wdata[7:0]);
  assign bsr_idx = bus_wdata[IDX_W:1];
  assign bsr_val = bus_wdata[0];
endmodule

// File: rtl/pio_mode_reg.sv
module pio_mode_reg
  import pio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tri_mode,
  input  logic            mode_wr,
  input  logic            rel_wr,
  input  logic [NGRP-1:0] new_dir,
  output logic [NGRP-1:0] dir_q,
  output logic            float_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '1;
      float_q <= 1'b0;
    end else if (mode_wr) begin
      dir_q <= new_dir;
      if (tri_mode) float_q <= 1'b1;
    end else if (rel_wr) begin
      float_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_latch_grp.sv
module pio_latch_grp #(
  parameter int unsigned GW     = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned BASE   = 0,
  parameter bit          BSR_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_in,
  input  logic             clr,
  input  logic             wr,
  input  logic [GW-1:0]    wr_data,
  input  logic             bsr_wr,
  input  logic [IDX_W-1:0] bsr_idx,
  input  logic             bsr_val,
  output logic [GW-1:0]    lat_q
);
  logic [GW-1:0] lat_nxt;

  always_comb begin
    lat_nxt = lat_q;
    if (clr) begin
      lat_nxt = '0;
    end else if (!is_in) begin
      if (wr) lat_nxt = wr_data;
      for (int i = 0; i < int'(GW); i++) begin
        if (BSR_EN && bsr_wr && (int'(bsr_idx) == int'(BASE) + i))
          lat_nxt[i] = bsr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_nxt;
  end
endmodule

// File: rtl/pio_tristate_ports.sv
module pio_tristate_ports
  import pio_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned HALF_W = PORT_W / 2,
  localparam int unsigned IDX_W  = $clog2(PORT_W),
  localparam int unsigned NP     = 3 * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tri_mode,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [NP-1:0]     pad_in,
  output logic [NP-1:0]     pin_out,
  output logic [NP-1:0]     pin_oe
);
  logic [2:0]       port_wr;
  logic             mode_wr;
  logic             bsr_wr;
  logic             rel_wr;
  logic [NGRP-1:0]  new_dir;
  logic [IDX_W-1:0] bsr_idx;
  logic             bsr_val;
  logic [NGRP-1:0]  dir_q;
  logic             float_q;

  pio_bus_dec #(.PORT_W(PORT_W)) u_dec (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .port_wr  (port_wr),
    .mode_wr  (mode_wr),
    .bsr_wr   (bsr_wr),
    .rel_wr   (rel_wr),
    .new_dir  (new_dir),
    .bsr_idx  (bsr_idx),
    .bsr_val  (bsr_val)
  );

  pio_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .tri_mode(tri_mode),
    .mode_wr (mode_wr),
    .rel_wr  (rel_wr),
    .new_dir (new_dir),
    .dir_q   (dir_q),
    .float_q (float_q)
  );

  for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
    localparam int unsigned GW   = (g < 2) ? PORT_W : HALF_W;
    localparam int unsigned LSB  = (g == 0) ? 0 :
                                   (g == 1) ? PORT_W :
                                   (g == 2) ? 2 * PORT_W + HALF_W : 2 * PORT_W;
    localparam int unsigned DLSB = (g == 2) ? HALF_W : 0;
    localparam int unsigned BASE = (g == 2) ? HALF_W : 0;
    localparam int unsigned PWI  = (g < 2) ? g : 2;

    pio_latch_grp #(
      .GW    (GW),
      .IDX_W (IDX_W),
      .BASE  (BASE),
      .BSR_EN(g >= 2)
    ) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .is_in  (dir_q[g]),
      .clr    (mode_wr),
      .wr     (port_wr[PWI]),
      .wr_data(bus_wdata[DLSB +: GW]),
      .bsr_wr (bsr_wr),
      .bsr_idx(bsr_idx),
      .bsr_val(bsr_val),
      .lat_q  (pin_out[LSB +: GW])
    );

    assign pin_oe[LSB +: GW] = {GW{!dir_q[g] && !float_q}};
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_A:    bus_rdata = pad_in[0 +: PORT_W];
      OFS_B:    bus_rdata = pad_in[PORT_W +: PORT_W];
      OFS_C:    bus_rdata = pad_in[2*PORT_W +: PORT_W];
      OFS_CTRL: begin
        bus_rdata[7]        = 1'b1;
        bus_rdata[NGRP-1:0] = dir_q;
      end
      OFS_REL:  bus_rdata[0] = float_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_tristate_ports_chk.sv
module pio_tristate_ports_chk #(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned NP = 3 * PORT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tri_mode,
  input logic          mode_wr,
  input logic          bsr_wr,
  input logic          rel_wr,
  input logic [2:0]    port_wr,
  input logic [3:0]    dir_q,
  input logic          float_q,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_oe
);
  p_mode_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pin_out == '0));

  p_mode_floats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mode && mode_wr) |=> (float_q && (pin_oe == '0)));

  p_normal_nofloat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_mode |-> !float_q);

  p_bsr_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> ($stable(float_q) && $stable(dir_q)));

  p_release_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_wr |=> !float_q);

  p_float_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (float_q && !rel_wr) |=> (float_q && (pin_oe == '0)));

  p_input_port_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr[0] && dir_q[0]) |=> $stable(pin_out[PORT_W-1:0]));
endmodule

bind pio_tristate_ports pio_tristate_ports_chk #(.PORT_W(PORT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tri_mode(tri_mode),
  .mode_wr (mode_wr),
  .bsr_wr  (bsr_wr),
  .rel_wr  (rel_wr),
  .port_wr (port_wr),
  .dir_q   (dir_q),
  .float_q (float_q),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/pio_tristate_ports_tb.sv
module pio_tristate_ports_tb;
  localparam int W  = 8;
  localparam int H  = W / 2;
  localparam int NP = 3 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tri_mode = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [NP-1:0] ext_val = '1;
  wire  [W-1:0]  bus_rdata;
  wire  [NP-1:0] pad_in;
  wire  [NP-1:0] pin_out;
  wire  [NP-1:0] pin_oe;

  logic [3:0]    m_dir;
  logic [NP-1:0] m_lat;
  logic          m_flt;
  int checks = 0;
  int errors = 0;

  assign pad_in = (pin_oe & pin_out) | (~pin_oe & ext_val);

  pio_tristate_ports #(.PORT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tri_mode(tri_mode), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #4 clk = ~clk;

  function automatic int grp_of(input int b);
    if (b < W) return 0;
    if (b < 2 * W) return 1;
    if (b >= 2 * W + H) return 2;
    return 3;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] e;
    for (int b = 0; b < NP; b++) e[b] = !m_flt && !m_dir[grp_of(b)];
    return e;
  endfunction

  function automatic logic [NP-1:0] exp_pad();
    logic [NP-1:0] oe;
    oe = exp_oe();
    return (oe & m_lat) | (~oe & ext_val);
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [2:0] a);
    logic [NP-1:0] p;
    logic [W-1:0]  r;
    p = exp_pad();
    r = '0;
    case (a)
      3'd0: r = p[0 +: W];
      3'd1: r = p[W +: W];
      3'd2: r = p[2*W +: W];
      3'd3: begin r[7] = 1'b1; r[3:0] = m_dir; end
      3'd4: r[0] = m_flt;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [W-1:0] d);
    int idx;
    case (a)
      3'd0: if (!m_dir[0]) m_lat[0 +: W] = d;
      3'd1: if (!m_dir[1]) m_lat[W +: W] = d;
      3'd2: begin
        if (!m_dir[2]) m_lat[2*W+H +: H] = d[W-1:H];
        if (!m_dir[3]) m_lat[2*W +: H] = d[H-1:0];
      end
      3'd3: begin
        if (d[7]) begin
          m_dir = d[3:0];
          m_lat = '0;
          if (tri_mode) m_flt = 1'b1;
        end else begin
          idx = int'(d[3:1]);
          if (!m_dir[(idx >= H) ? 2 : 3]) m_lat[2*W + idx] = d[0];
        end
      end
      3'd4: if (d[0]) m_flt = 1'b0;
      default: ;
    endcase
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic pins_chk(input string tag);
    chk({tag, " pin_out"}, pin_out, m_lat);
    chk({tag, " pin_oe"}, pin_oe, exp_oe());
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a);
    bus_addr = a;
    #1;
    chk({tag, " read"}, NP'(bus_rdata), NP'(exp_read(a)));
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; tri_mode = mode; bus_we = 1'b0; ext_val = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_dir = 4'hF; m_lat = '0; m_flt = 1'b0;
    pins_chk("R1 reset");
    rd_chk("R1 float flag", 3'd4);
  endtask

  task automatic random_run(input int n, input string tag);
    logic [2:0] a;
    logic [W-1:0] d;
    for (int i = 0; i < n; i++) begin
      a = 3'($urandom % 5);
      d = W'($urandom);
      if (a == 3'd3 && ($urandom % 3 == 0)) d[7] = 1'b1;
      if (a == 3'd4 && ($urandom % 2 == 0)) d[0] = 1'b1;
      bus_wr(a, d);
      pins_chk({tag, " R4 random"});
      if (i % 4 == 0) begin
        ext_val = NP'($urandom);
        rd_chk({tag, " R5 random"}, 3'($urandom % 5));
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    // ---------------- normal mode ----------------
    do_reset(1'b0);
    bus_wr(3'd3, 8'h80);
    pins_chk("R2 all outputs");
    bus_wr(3'd0, 8'h5A); bus_wr(3'd1, 8'hC3); bus_wr(3'd2, 8'h96);
    pins_chk("R4 port writes");
    rd_chk("R5 port C readback", 3'd2);
    bus_wr(3'd3, 8'h85);
    pins_chk("R3 latch clear R2 dir");
    rd_chk("R5 control readback", 3'd3);
    bus_wr(3'd0, 8'hFF);
    pins_chk("R4 input port A ignored");
    bus_wr(3'd2, 8'hFF);
    pins_chk("R4 C lower only");
    ext_val = 24'hA5C33C;
    rd_chk("R5 input A pads", 3'd0);
    rd_chk("R5 port B drive", 3'd1);
    bus_wr(3'd3, 8'h04);
    pins_chk("R6 clear C bit 2");
    bus_wr(3'd3, 8'h0D);
    pins_chk("R6 input half ignored");
    rd_chk("R6 dir kept", 3'd3);
    bus_wr(3'd4, 8'h01);
    pins_chk("R10 release no effect");
    rd_chk("R10 flag clear", 3'd4);
    random_run(400, "normal");
    // ---------------- float mode ----------------
    do_reset(1'b1);
    bus_wr(3'd3, 8'h80);
    pins_chk("R7 mode floats");
    rd_chk("R7 flag set", 3'd4);
    ext_val = '1;
    rd_chk("R7 pull-up A", 3'd0);
    bus_wr(3'd0, 8'h12); bus_wr(3'd1, 8'h34); bus_wr(3'd2, 8'h56);
    pins_chk("R8 reload floated");
    bus_wr(3'd3, 8'h0F);
    pins_chk("R6 no float change");
    bus_wr(3'd4, 8'h00);
    pins_chk("R9 zero release ignored");
    bus_wr(3'd4, 8'h01);
    pins_chk("R9 release drives");
    rd_chk("R9 flag clear", 3'd4);
    bus_wr(3'd3, 8'h8A);
    pins_chk("R7 refloat");
    random_run(400, "float");
    finish_run();
  end
endmodule